// File: doc/BRIEF.md
# IDE Controller Configuration Register Port

This block holds the configuration register file of an IDE controller and decodes the host I/O cycles that reach it. Three access paths lead into one storage. The first is a local-bus index/data port pair. The second is PCI configuration mechanism 1: a dword address latch plus a byte data window. The third is PCI configuration mechanism 2: an enable key plus a mapped I/O window. Any mix of the three paths reads and writes the same bytes.

The host side is a plain I/O bus. It has a 16-bit address, separate write and read strobes, a dword-size flag, 32 bits of write data and a byte of read data. Read data is registered. The register file holds the identification bytes, a read-only configuration byte, the control byte, the timing bytes and one scratch byte. The per-drive timing fields, the prefetch-disable bits and the secondary-channel enable are exported to the timing engine.

A strap input moves the local-bus port pair between two base addresses, and that strap can be read back in the configuration byte. The only dword cycle the block honours is the write of the mechanism 1 address latch. Every configuration data write must be a byte wide.

Top module: `ide_cfg_port`

## Requirements
- R1: Offsets 0x00, 0x01, 0x02 and 0x03 read the constants 0x95, 0x10, 0x40 and 0x06. Writes to them change nothing.
- R2: Offset 0x50 is read-only. Bits 1:0 read the nonzero parameter REV, bit 5 reads the strap input `strap_alt_base`, and all other bits read 0.
- R3: A byte write to the local-bus base port loads the register index. A byte access at base+4 reads or writes the register that the index selects. The base is 0x178 when the strap is low and 0x078 when it is high.
- R4: A dword write to 0xCF8 loads the 32-bit mechanism 1 address. A byte access at 0xCFC+n (n = 0..3) reaches offset {addr[7:2], n}, but only when addr[31] is 1 and addr[15:11] equals DEV_NUM. Otherwise a read returns 0xFF and a write is dropped.
- R5: A byte write to 0xCF8 loads the mechanism 2 key. While key bit 4 is 1, a byte access at 0xC000 + (DEV_NUM[3:0] << 8) + off reaches offset off. While key bit 4 is 0, that window reads 0xFF. Addresses 0xCF8 to 0xCFF never fall into the window.
- R6: A dword access to any data port is not honoured. A dword write changes no register, and a dword read returns 0xFF.
- R7: Offset 0x5B is a scratch byte that reads back the last value written to it.
- R8: Offsets 0x51 to 0x59 are writable full bytes that reset to 0. The `pf_dis_o` output is {0x57[3], 0x57[2], 0x51[7], 0x51[6]} for drives 3..0, and `sec_chan_en_o` is 0x51[3].
- R9: Drive d's setup code is bits 7:6 of 0x53, 0x55 and 0x57 for d = 0, 1 and 2/3. Its active count is the upper nibble and its recovery count the lower nibble of 0x54, 0x56 and 0x58 for the same groups. Drives 2 and 3 share registers. `cmd_timing_o` is 0x52 and `burst_o` is 0x59.
- R10: Any other offset reads 0x00 and ignores writes.
- R11: Read data appears one cycle after the read strobe and holds until the next read. After reset, read data and all writable bytes are 0.
- R12: A read of an I/O address no path decodes returns 0xFF. This includes the index port and 0xCF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt_base | input | 1 | Selects local-bus base 0x078 (1) or 0x178 (0) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_dword | input | 1 | 1 = dword cycle, 0 = byte cycle |
| io_wdata | input | 32 | Write data (byte cycles use bits 7:0) |
| io_rdata | output | 8 | Registered read data |
| pf_dis_o | output | 4 | Prefetch disable per drive |
| sec_chan_en_o | output | 1 | Secondary channel enable |
| cmd_timing_o | output | 8 | Command block timing byte |
| burst_o | output | 8 | Burst control byte |
| drv_setup_o | output | 8 | 2-bit setup code per drive |
| drv_active_o | output | 16 | 4-bit active count per drive |
| drv_recov_o | output | 16 | 4-bit recovery count per drive |

## Verification
A corrupted index, mechanism 1 address or key shows up as wrong read data one cycle after the next read on that path. It also shows up as a write that lands on the wrong exported field, visible one cycle after the write. A corrupted control or timing byte appears on the export pins in the cycle after the edge that stores it. The bench therefore compares read data and every export pin against its model on every clock. This catches a fault within one cycle of the access that exposes it.

// File: rtl/idecfg_pkg.sv
package idecfg_pkg;

    localparam int NUM_DRIVES = 4;
    localparam logic [7:0] OFF_CFG     = 8'h50;
    localparam logic [7:0] OFF_TIM_LO  = 8'h51;
    localparam logic [7:0] OFF_TIM_HI  = 8'h59;
    localparam logic [7:0] OFF_SCRATCH = 8'h5B;
    localparam int TIM_CNT = int'(OFF_TIM_HI - OFF_TIM_LO) + 1;

    typedef struct packed {
        logic       hit;
        logic       wr;
        logic       rd;
        logic [7:0] off;
    } acc_t;

    function automatic logic [7:0] id_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'h95;
            2'd1:    return 8'h10;
            2'd2:    return 8'h40;
            default: return 8'h06;
        endcase
    endfunction

endpackage

// File: rtl/idecfg_decode.sv
module idecfg_decode
    import idecfg_pkg::*;
#(
    parameter logic [4:0]  DEV_NUM    = 5'd3,
    parameter logic [15:0] LB_BASE_HI = 16'h0178,
    parameter logic [15:0] LB_BASE_LO = 16'h0078
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_alt_base,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic        io_dword,
    input  logic [31:0] io_wdata,
    output acc_t        acc_o
);

    localparam logic [15:0] PCI_ADDR_PORT = 16'h0CF8;
    localparam logic [13:0] PCI_DATA_DW   = 14'(16'h0CFC >> 2);
    localparam logic [12:0] PCI_PORTS_QW  = 13'(16'h0CF8 >> 3);
    localparam logic [3:0]  M2_TOP        = 4'hC;

    typedef struct packed {
        logic [7:0]  index;
        logic [31:0] m1addr;
        logic [7:0]  key;
    } dec_st_t;

    dec_st_t st_d, st_q;
    acc_t    acc_d;
    logic [15:0] lb_base;
    logic        at_addr_port, in_data_port, in_pci_ports, in_m2_win, m1_open;

    always_comb begin
        st_d    = st_q;
        acc_d   = '0;
        lb_base = strap_alt_base ? LB_BASE_LO : LB_BASE_HI;
        at_addr_port = (io_addr == PCI_ADDR_PORT);
        in_data_port = (io_addr[15:2] == PCI_DATA_DW);
        in_pci_ports = (io_addr[15:3] == PCI_PORTS_QW);
        in_m2_win    = (io_addr[15:12] == M2_TOP) && (io_addr[11:8] == DEV_NUM[3:0]);
        m1_open      = st_q.m1addr[31] && (st_q.m1addr[15:11] == DEV_NUM);

        if (io_wr && io_dword && at_addr_port)
            st_d.m1addr = io_wdata;
        if (io_wr && !io_dword) begin
            if (io_addr == lb_base)
                st_d.index = io_wdata[7:0];
            if (at_addr_port)
                st_d.key = io_wdata[7:0];
        end

        if (!io_dword) begin
            if (io_addr == lb_base + 16'd4) begin
                acc_d.hit = 1'b1;
                acc_d.off = st_q.index;
            end else if (in_data_port && m1_open) begin
                acc_d.hit = 1'b1;
                acc_d.off = {st_q.m1addr[7:2], io_addr[1:0]};
            end else if (!in_pci_ports && in_m2_win && st_q.key[4]) begin
                acc_d.hit = 1'b1;
                acc_d.off = io_addr[7:0];
            end
        end
        acc_d.wr = acc_d.hit && io_wr;
        acc_d.rd = acc_d.hit && io_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = acc_d;

    // R3: a byte write to the local-bus base port loads the index
    p_index_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_dword && io_addr == (strap_alt_base ? LB_BASE_LO : LB_BASE_HI))
        |=> st_q.index == $past(io_wdata[7:0]));

    // R4: a dword write to the address port loads the mechanism 1 address
    p_m1_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_dword && io_addr == PCI_ADDR_PORT) |=> st_q.m1addr == $past(io_wdata));

    // R6: dword cycles never reach the register file
    p_dword_nohit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_dword |-> !acc_o.hit);

endmodule

// File: rtl/idecfg_regs.sv
module idecfg_regs
    import idecfg_pkg::*;
#(
    parameter logic [1:0] REV = 2'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  acc_t        acc_i,
    input  logic [7:0]  wdata_i,
    input  logic        strap_i,
    output logic [7:0]  rd_byte_o,
    output logic [NUM_DRIVES-1:0]   pf_dis_o,
    output logic                    sec_en_o,
    output logic [7:0]              cmd_tim_o,
    output logic [7:0]              burst_o,
    output logic [2*NUM_DRIVES-1:0] setup_o,
    output logic [4*NUM_DRIVES-1:0] active_o,
    output logic [4*NUM_DRIVES-1:0] recov_o
);

    localparam int IDX_W = $clog2(TIM_CNT);

    typedef struct packed {
        logic [TIM_CNT-1:0][7:0] tim;
        logic [7:0]              scratch;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    in_tim, wr_able;
    logic [IDX_W-1:0] tidx;

    always_comb begin
        st_d    = st_q;
        in_tim  = (acc_i.off >= OFF_TIM_LO) && (acc_i.off <= OFF_TIM_HI);
        wr_able = in_tim || (acc_i.off == OFF_SCRATCH);
        tidx    = IDX_W'(acc_i.off - OFF_TIM_LO);

        if (acc_i.wr && in_tim)
            st_d.tim[tidx] = wdata_i;
        if (acc_i.wr && acc_i.off == OFF_SCRATCH)
            st_d.scratch = wdata_i;

        if (acc_i.off < 8'h04)
            rd_byte_o = id_byte(acc_i.off[1:0]);
        else if (acc_i.off == OFF_CFG)
            rd_byte_o = {2'b00, strap_i, 3'b000, REV};
        else if (in_tim)
            rd_byte_o = st_q.tim[tidx];
        else if (acc_i.off == OFF_SCRATCH)
            rd_byte_o = st_q.scratch;
        else
            rd_byte_o = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        localparam int GRP    = (d < 2) ? d : 2;
        localparam int AS_IDX = 2 + 2 * GRP;
        localparam int RW_IDX = AS_IDX + 1;
        localparam int PF_IDX = (d < 2) ? 0 : 6;
        localparam int PF_BIT = (d < 2) ? 6 + d : d;
        assign setup_o[2*d +: 2]  = st_q.tim[AS_IDX][7:6];
        assign active_o[4*d +: 4] = st_q.tim[RW_IDX][7:4];
        assign recov_o[4*d +: 4]  = st_q.tim[RW_IDX][3:0];
        assign pf_dis_o[d]        = st_q.tim[PF_IDX][PF_BIT];
    end

    assign sec_en_o  = st_q.tim[0][3];
    assign cmd_tim_o = st_q.tim[1];
    assign burst_o   = st_q.tim[TIM_CNT-1];

    // R8: a control write lands on the drive 0/1 prefetch-disable outputs
    p_ctrl_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.wr && acc_i.off == OFF_TIM_LO) |=> pf_dis_o[1:0] == $past(wdata_i[7:6]));

    // R7: the scratch byte keeps the value last written
    p_scratch_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.wr && acc_i.off == OFF_SCRATCH) |=> st_q.scratch == $past(wdata_i));

    // R10: writes outside the writable set change no storage
    p_ignore_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.wr && !((acc_i.off >= OFF_TIM_LO && acc_i.off <= OFF_TIM_HI)
                       || acc_i.off == OFF_SCRATCH)) |=> $stable(st_q));

endmodule

// File: rtl/ide_cfg_port.sv
module ide_cfg_port
    import idecfg_pkg::*;
#(
    parameter logic [4:0] DEV_NUM = 5'd3,
    parameter logic [1:0] REV     = 2'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_alt_base,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic        io_dword,
    input  logic [31:0] io_wdata,
    output logic [7:0]  io_rdata,
    output logic [3:0]  pf_dis_o,
    output logic        sec_chan_en_o,
    output logic [7:0]  cmd_timing_o,
    output logic [7:0]  burst_o,
    output logic [7:0]  drv_setup_o,
    output logic [15:0] drv_active_o,
    output logic [15:0] drv_recov_o
);

    acc_t       acc;
    logic [7:0] rd_byte;
    logic [7:0] rdata_d, rdata_q;

    idecfg_decode #(.DEV_NUM(DEV_NUM)) u_decode (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_alt_base (strap_alt_base),
        .io_addr        (io_addr),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_dword       (io_dword),
        .io_wdata       (io_wdata),
        .acc_o          (acc)
    );

    idecfg_regs #(.REV(REV)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (acc),
        .wdata_i   (io_wdata[7:0]),
        .strap_i   (strap_alt_base),
        .rd_byte_o (rd_byte),
        .pf_dis_o  (pf_dis_o),
        .sec_en_o  (sec_chan_en_o),
        .cmd_tim_o (cmd_timing_o),
        .burst_o   (burst_o),
        .setup_o   (drv_setup_o),
        .active_o  (drv_active_o),
        .recov_o   (drv_recov_o)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (io_rd)
            rdata_d = acc.hit ? rd_byte : 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign io_rdata = rdata_q;

    // R11: read data holds when no read strobe is given
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

    // R6: a dword read returns all ones
    p_dword_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_dword) |=> io_rdata == 8'hFF);

    // R1: identification offsets return their constants
    p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.off < 8'h04) |=> io_rdata == id_byte($past(acc.off[1:0])));

    // R2: configuration byte carries a nonzero revision and the strap
    p_cfg_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.off == OFF_CFG)
        |=> (io_rdata[1:0] != 2'b00) && (io_rdata[5] == $past(strap_alt_base)));

endmodule

// File: tb/ide_cfg_port_tb.sv
module ide_cfg_port_tb_top;

    localparam logic [4:0] DEV = 5'd3;
    localparam logic [1:0] REV = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0, dw = 1'b0;
    logic [31:0] wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  pf_dis;
    logic        sec_en;
    logic [7:0]  cmd_tim, burst, setup;
    logic [15:0] active, recov;

    int checks = 0, fails = 0;
    bit comparing = 0, done = 0;
    string cur_req = "R11";

    // behavioural model state
    logic [7:0]  m_mem [256];
    logic [7:0]  m_index, m_key, exp_rdata;
    logic [31:0] m_m1;

    always #2.5 clk = ~clk;

    ide_cfg_port #(.DEV_NUM(DEV), .REV(REV)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_alt_base(strap),
        .io_addr(addr), .io_wr(wr), .io_rd(rd), .io_dword(dw), .io_wdata(wdata),
        .io_rdata(rdata), .pf_dis_o(pf_dis), .sec_chan_en_o(sec_en),
        .cmd_timing_o(cmd_tim), .burst_o(burst), .drv_setup_o(setup),
        .drv_active_o(active), .drv_recov_o(recov)
    );

    function automatic bit writable(int off);
        return (off >= 'h51 && off <= 'h59) || off == 'h5B;
    endfunction

    function automatic logic [7:0] model_read(int off);
        if (off == 0) return 8'h95;
        if (off == 1) return 8'h10;
        if (off == 2) return 8'h40;
        if (off == 3) return 8'h06;
        if (off == 'h50) return {2'b00, strap, 3'b000, REV};
        if (writable(off)) return m_mem[off];
        return 8'h00;
    endfunction

    // which register offset an access reaches, or -1 (R3, R4, R5, R6)
    function automatic int target(logic [15:0] a, bit is_dw);
        int base;
        base = strap ? 'h78 : 'h178;
        if (is_dw) return -1;
        if (int'(a) == base + 4) return int'(m_index);
        if (a >= 16'h0CFC && a <= 16'h0CFF)
            return (m_m1[31] && m_m1[15:11] == DEV) ? int'({m_m1[7:2], a[1:0]}) : -1;
        if (a >= 16'h0CF8 && a <= 16'h0CFB) return -1;
        if (a[15:8] == {4'hC, DEV[3:0]} && m_key[4]) return int'(a[7:0]);
        return -1;
    endfunction

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (comparing && !done) begin
            check(rdata == exp_rdata, "rdata", rdata, exp_rdata);
            check(pf_dis == {m_mem['h57][3], m_mem['h57][2], m_mem['h51][7], m_mem['h51][6]},
                  "R8 pf_dis", pf_dis, 0);
            check(sec_en == m_mem['h51][3], "R8 sec_en", sec_en, m_mem['h51][3]);
            check(cmd_tim == m_mem['h52] && burst == m_mem['h59], "R9 cmd/burst",
                  {cmd_tim, burst}, {m_mem['h52], m_mem['h59]});
            check(setup == {m_mem['h57][7:6], m_mem['h57][7:6], m_mem['h55][7:6], m_mem['h53][7:6]},
                  "R9 setup", setup, 0);
            check(active == {m_mem['h58][7:4], m_mem['h58][7:4], m_mem['h56][7:4], m_mem['h54][7:4]}
                  && recov == {m_mem['h58][3:0], m_mem['h58][3:0], m_mem['h56][3:0], m_mem['h54][3:0]},
                  "R9 active/recov", {active, recov}, 0);
        end
    end

    task automatic cyc(logic [15:0] a, bit w, bit r, bit is_dw, logic [31:0] d);
        int t;
        int base;
        @(negedge clk); #1;
        addr = a; wr = w; rd = r; dw = is_dw; wdata = d;
        base = strap ? 'h78 : 'h178;
        t = target(a, is_dw);
        if (r) exp_rdata = (t >= 0) ? model_read(t) : 8'hFF;
        if (w) begin
            if (t >= 0 && writable(t)) m_mem[t] = d[7:0];
            if (!is_dw && int'(a) == base) m_index = d[7:0];
            if (!is_dw && a == 16'h0CF8) m_key = d[7:0];
            if (is_dw && a == 16'h0CF8) m_m1 = d;
        end
        @(negedge clk); #1;
        addr = '0; wr = 0; rd = 0; dw = 0; wdata = '0;
    endtask

    task automatic wb(logic [15:0] a, logic [31:0] d); cyc(a, 1, 0, 0, d); endtask
    task automatic rb(logic [15:0] a);                 cyc(a, 0, 1, 0, 0); endtask
    task automatic lb_sel(logic [7:0] off); wb(strap ? 16'h78 : 16'h178, {24'h0, off}); endtask
    task automatic lb_wr(logic [7:0] off, logic [7:0] d); lb_sel(off); wb(strap ? 16'h7C : 16'h17C, {24'h0, d}); endtask
    task automatic lb_rd(logic [7:0] off); lb_sel(off); rb(strap ? 16'h7C : 16'h17C); endtask

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_index = 0; m_key = 0; m_m1 = 0; exp_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        comparing = 1;
        cur_req = "R11"; repeat (2) @(negedge clk);

        cur_req = "R1";
        for (int i = 0; i < 4; i++) lb_rd(8'(i));
        lb_wr(8'h01, 8'h5A); lb_rd(8'h01);

        cur_req = "R2";
        lb_rd(8'h50); lb_wr(8'h50, 8'hFF); lb_rd(8'h50);

        cur_req = "R3";
        lb_wr(8'h51, 8'hC8); lb_rd(8'h51); lb_wr(8'h57, 8'h0C); lb_rd(8'h57);

        cur_req = "R4";
        cyc(16'h0CF8, 1, 0, 1, 32'h8000_1850);
        rb(16'h0CFD); wb(16'h0CFE, 32'h33); rb(16'h0CFE); lb_rd(8'h52);
        cyc(16'h0CF8, 1, 0, 1, 32'h8000_2050);
        rb(16'h0CFD); wb(16'h0CFE, 32'h77); lb_rd(8'h52);
        cyc(16'h0CF8, 1, 0, 1, 32'h0000_1850);
        rb(16'h0CFC);

        cur_req = "R5";
        wb(16'h0CF8, 32'h10);
        rb(16'hC351); wb(16'hC354, 32'hA5); rb(16'hC354); rb(16'hC300);
        rb(16'hC451);
        wb(16'h0CF8, 32'h00); rb(16'hC354); wb(16'hC354, 32'h11); lb_rd(8'h54);

        cur_req = "R6";
        wb(16'h0CF8, 32'h10);
        lb_sel(8'h55); cyc(16'h017C, 1, 0, 1, 32'hFFFF_FFFF); cyc(16'h017C, 0, 1, 1, 0);
        cyc(16'hC355, 1, 0, 1, 32'h99); lb_rd(8'h55);

        cur_req = "R7";
        lb_wr(8'h5B, 8'hBD); lb_rd(8'h5B); wb(16'hC35B, 32'h42); rb(16'hC35B);
        cyc(16'h0CF8, 1, 0, 1, 32'h8000_1858); wb(16'h0CFF, 32'h00); rb(16'h0CFF);

        cur_req = "R8";
        lb_wr(8'h51, 8'h40); lb_wr(8'h51, 8'h88); lb_wr(8'h57, 8'h04);

        cur_req = "R9";
        lb_wr(8'h52, 8'h3C); lb_wr(8'h53, 8'h80); lb_wr(8'h54, 8'hF1);
        lb_wr(8'h55, 8'h40); lb_wr(8'h56, 8'h2E); lb_wr(8'h57, 8'hC8);
        lb_wr(8'h58, 8'h00); lb_wr(8'h59, 8'h40);

        cur_req = "R10";
        lb_wr(8'h5A, 8'h12); lb_rd(8'h5A); wb(16'hC320, 32'h34); rb(16'hC320); rb(16'hC3FF);

        cur_req = "R12";
        rb(16'h1234); rb(16'h0178); rb(16'h0CF8); rb(16'h0CF9);

        cur_req = "R3";
        strap = 1'b1; @(negedge clk);
        lb_rd(8'h51); lb_wr(8'h5B, 8'h6E); rb(16'h017C);
        cur_req = "R2"; lb_rd(8'h50);

        cur_req = "R11";
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule